// File: doc/BRIEF.md
# Half-Duplex Transceive Loop Sequencer

This block controls when a half-duplex radio front end sends and when it listens. Software writes the transceive command code into the command port. The sequencer then alternates between a transmit phase and a receive phase, and keeps doing so until a different command is written. A configuration input picks the first phase. With it high, the loop sends first. With it low, the loop listens first and sends only after a whole frame has arrived.

Each transmission has to be allowed by software. A start-send bit must be set, and the sequencer waits in a wait-send phase until it is set. The bit clears itself when the transmitter start strobe is issued. A receive-multiple mode bit keeps the loop in receive once it gets there. The transmitter and receiver are outside this block. They are seen only through their completion strobes. The sequencer reports its phase and gives a one-cycle event for every accepted completion.

Top module: `trx_seq_top`

## Requirements
- R1: A clock edge with `rst_n` low leaves phase idle (2'b00), `start_pending` low, and `tx_start`, `rx_en`, `ev_tx_done` and `ev_rx_frame` all low.
- R2: `phase` encodes idle as 2'b00, wait-send as 2'b01, transmit as 2'b10 and receive as 2'b11. `rx_en` is high exactly when `phase` is receive.
- R3: Writing command code 4'hC while idle moves the phase on the next edge. It goes to wait-send if `initiator` is 1, and to receive if `initiator` is 0.
- R4: `send_set` sets `start_pending`. In wait-send with `start_pending` high, the next edge raises `tx_start` for one cycle, enters transmit and clears `start_pending`. A `send_set` in that same cycle keeps the bit set.
- R5: In transmit, `tx_done` moves the phase to receive on the next edge and pulses `ev_tx_done` for one cycle.
- R6: In receive with `rx_multi` low, `rx_frame` moves the phase to wait-send on the next edge and pulses `ev_rx_frame` for one cycle.
- R7: In receive with `rx_multi` high, `rx_frame` still pulses `ev_rx_frame`, but the phase stays receive.
- R8: `tx_done` outside transmit and `rx_frame` outside receive produce no event and no phase change.
- R9: Writing any code other than 4'hC returns the phase to idle on the next edge. Idle is left only by a write of 4'hC.
- R10: Writing 4'hC while the loop is active sends it straight to the initial phase chosen by `initiator`, with no idle cycle in between.
- R11: In a cycle with `cmd_we` high, the completion strobes produce no events and no `tx_start` is issued.
- R12: `tx_start` and `rx_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 4 | Command code written (4'hC = transceive) |
| initiator | input | 1 | 1: loop starts with transmit, 0: with receive |
| send_set | input | 1 | Software write that sets the start-send bit |
| rx_multi | input | 1 | Receive-multiple mode: receive is never left |
| tx_done | input | 1 | Transmitter finished a frame |
| rx_frame | input | 1 | Receiver delivered a complete frame |
| tx_start | output | 1 | One-cycle transmitter start strobe |
| rx_en | output | 1 | Receiver enable |
| phase | output | 2 | Current phase (encoding per R2) |
| start_pending | output | 1 | Start-send bit |
| ev_tx_done | output | 1 | One-cycle accepted transmit-done event |
| ev_rx_frame | output | 1 | One-cycle accepted frame-received event |

## Verification
The corners that are hardest to reach from the ports are a command write that coincides with a completion strobe or with a pending start, and a restart issued from each active phase. Random stimulus seldom lines these up with the right phase. The bench therefore first drives each phase into place with directed steps and then applies the clash. The receive-multiple lock is held for many cycles of frames. This shows that no frame releases it and that only a command write does. A cycle-accurate model in the bench checks all outputs on every cycle of the long random run.

// File: rtl/trx_seq_pkg.sv
// Shared types for the transceive loop sequencer.
// Assumes: phase encoding is visible at the top ports and must stay fixed.
package trx_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_TX   = 2'd2,
        PH_RX   = 2'd3
    } phase_t;
endpackage

// File: rtl/trx_cmd_decode.sv
// Decodes a command-port write into "start/restart loop" or "go idle".
// Assumes: every write of a code other than the transceive code ends the loop.
module trx_cmd_decode #(
    parameter int unsigned         CMD_W    = 4,
    parameter logic [CMD_W-1:0]    XCV_CODE = 4'hC
) (
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             go_xcv,
    output logic             go_idle
);
    // Split a write into its two possible outcomes.
    always_comb begin
        go_xcv  = cmd_we && (cmd_code == XCV_CODE);
        go_idle = cmd_we && (cmd_code != XCV_CODE);
    end
endmodule

// File: rtl/trx_send_arm.sv
// Start-send bit: set by software, cleared when a transmission is launched.
// Assumes: a set in the same cycle as a launch wins, so that write is kept.
module trx_send_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic fire,
    output logic pending
);
    // Hold the arm bit between the software write and the launch.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (set_req) pending <= 1'b1;
        else if (fire)    pending <= 1'b0;
    end
endmodule

// File: rtl/trx_phase_fsm.sv
// Phase state machine of the transmit/receive loop, with the start strobe
// and the completion events.
// Assumes: command writes have priority over every strobe in the same cycle.
module trx_phase_fsm
    import trx_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go_xcv,
    input  logic   go_idle,
    input  logic   initiator,
    input  logic   pending,
    input  logic   rx_multi,
    input  logic   tx_done,
    input  logic   rx_frame,
    output phase_t phase_q,
    output logic   fire,
    output logic   tx_start,
    output logic   ev_tx,
    output logic   ev_rx
);
    phase_t phase_d;
    logic   cmd_hit;
    phase_t init_phase;

    // Launch permission and the loop's entry phase.
    always_comb begin
        cmd_hit    = go_xcv || go_idle;
        fire       = !cmd_hit && (phase_q == PH_WAIT) && pending;
        init_phase = initiator ? PH_WAIT : PH_RX;
    end

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        if (go_idle)     phase_d = PH_IDLE;
        else if (go_xcv) phase_d = init_phase;
        else begin
            unique case (phase_q)
                PH_IDLE: phase_d = PH_IDLE;
                PH_WAIT: if (fire) phase_d = PH_TX;
                PH_TX:   if (tx_done) phase_d = PH_RX;
                PH_RX:   if (rx_frame && !rx_multi) phase_d = PH_WAIT;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register, start strobe and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            tx_start <= 1'b0;
            ev_tx    <= 1'b0;
            ev_rx    <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            tx_start <= fire;
            ev_tx    <= !cmd_hit && (phase_q == PH_TX) && tx_done;
            ev_rx    <= !cmd_hit && (phase_q == PH_RX) && rx_frame;
        end
    end
endmodule

// File: rtl/trx_seq_top.sv
// Half-duplex transceive loop sequencer: top level.
// Assumes: transmitter and receiver respond with single-cycle done strobes.
module trx_seq_top
    import trx_seq_pkg::*;
#(
    parameter int unsigned      CMD_W    = 4,
    parameter logic [CMD_W-1:0] XCV_CODE = 4'hC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             initiator,
    input  logic             send_set,
    input  logic             rx_multi,
    input  logic             tx_done,
    input  logic             rx_frame,
    output logic             tx_start,
    output logic             rx_en,
    output logic [1:0]       phase,
    output logic             start_pending,
    output logic             ev_tx_done,
    output logic             ev_rx_frame
);
    logic   go_xcv;
    logic   go_idle;
    logic   fire;
    phase_t phase_q;

    trx_cmd_decode #(.CMD_W(CMD_W), .XCV_CODE(XCV_CODE)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_code (cmd_code),
        .go_xcv   (go_xcv),
        .go_idle  (go_idle)
    );

    trx_send_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (send_set),
        .fire    (fire),
        .pending (start_pending)
    );

    trx_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_xcv    (go_xcv),
        .go_idle   (go_idle),
        .initiator (initiator),
        .pending   (start_pending),
        .rx_multi  (rx_multi),
        .tx_done   (tx_done),
        .rx_frame  (rx_frame),
        .phase_q   (phase_q),
        .fire      (fire),
        .tx_start  (tx_start),
        .ev_tx     (ev_tx_done),
        .ev_rx     (ev_rx_frame)
    );

    // Drive the status outputs from the phase register.
    always_comb begin
        phase = phase_q;
        rx_en = (phase_q == PH_RX);
    end
endmodule

// File: rtl/trx_seq_chk.sv
// Checker for trx_seq_top, attached with bind below.
// Assumes: it observes the top-level ports only.
module trx_seq_chk #(
    parameter int unsigned      CMD_W    = 4,
    parameter logic [CMD_W-1:0] XCV_CODE = 4'hC
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [CMD_W-1:0] cmd_code,
    input logic             initiator,
    input logic             send_set,
    input logic             rx_multi,
    input logic             tx_done,
    input logic             rx_frame,
    input logic             tx_start,
    input logic             rx_en,
    input logic [1:0]       phase,
    input logic             start_pending,
    input logic             ev_tx_done,
    input logic             ev_rx_frame
);
    logic rst_seen;

    // Remember that reset was applied at the previous edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // Reset state, checked on the first active edge after reset.
    always_ff @(posedge clk) begin
        if (rst_n && rst_seen === 1'b1) begin
            // R1
            rst_state_chk: assert (phase == 2'b00 && !start_pending && !tx_start
                                   && !rx_en && !ev_tx_done && !ev_rx_frame);
        end
    end

    // R12
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start && rx_en));

    // R4
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && start_pending && !cmd_we)
        |=> (tx_start && phase == 2'b10 && start_pending == $past(send_set)));

    // R3
    start_tx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_code == XCV_CODE && initiator) |=> (phase == 2'b01));

    // R10
    start_rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_code == XCV_CODE && !initiator) |=> (phase == 2'b11));

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_code != XCV_CODE) |=> (phase == 2'b00));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && !(cmd_we && cmd_code == XCV_CODE)) |=> (phase == 2'b00));

    // R7
    rx_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && rx_multi && !cmd_we) |=> (phase == 2'b11));

    // R5
    tx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && tx_done && !cmd_we) |=> (phase == 2'b11 && ev_tx_done));

    // R8
    stray_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'b11 && !cmd_we) |=> !ev_rx_frame);

    // R11
    cmd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (!tx_start && !ev_tx_done && !ev_rx_frame));
endmodule

bind trx_seq_top trx_seq_chk #(.CMD_W(CMD_W), .XCV_CODE(XCV_CODE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_we        (cmd_we),
    .cmd_code      (cmd_code),
    .initiator     (initiator),
    .send_set      (send_set),
    .rx_multi      (rx_multi),
    .tx_done       (tx_done),
    .rx_frame      (rx_frame),
    .tx_start      (tx_start),
    .rx_en         (rx_en),
    .phase         (phase),
    .start_pending (start_pending),
    .ev_tx_done    (ev_tx_done),
    .ev_rx_frame   (ev_rx_frame)
);

// File: tb/tb_trx_seq_top.sv
`timescale 1ns/1ps
module tb_trx_seq_top;
    localparam logic [3:0] XCV = 4'hC;
    localparam logic [1:0] P_IDLE = 2'd0, P_WAIT = 2'd1, P_TX = 2'd2, P_RX = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic       initiator = 1'b0;
    logic       send_set = 1'b0;
    logic       rx_multi = 1'b0;
    logic       tx_done = 1'b0;
    logic       rx_frame = 1'b0;
    logic       tx_start, rx_en, start_pending, ev_tx_done, ev_rx_frame;
    logic [1:0] phase;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    logic [1:0] m_ph;
    logic       m_pend, m_txs, m_evt, m_evr;

    always #2.5 clk = ~clk;

    trx_seq_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .initiator(initiator), .send_set(send_set), .rx_multi(rx_multi),
        .tx_done(tx_done), .rx_frame(rx_frame), .tx_start(tx_start),
        .rx_en(rx_en), .phase(phase), .start_pending(start_pending),
        .ev_tx_done(ev_tx_done), .ev_rx_frame(ev_rx_frame)
    );

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Next-state function of the requirements.
    function automatic logic [1:0] next_phase(logic [1:0] ph, logic pend);
        if (cmd_we) return (cmd_code == XCV) ? (initiator ? P_WAIT : P_RX) : P_IDLE;
        case (ph)
            P_WAIT:  return pend ? P_TX : P_WAIT;
            P_TX:    return tx_done ? P_RX : P_TX;
            P_RX:    return (rx_frame && !rx_multi) ? P_WAIT : P_RX;
            default: return P_IDLE;
        endcase
    endfunction

    // Apply current inputs for one edge, update model, compare outputs.
    task automatic step(string tag);
        logic fire;
        fire = !cmd_we && m_ph == P_WAIT && m_pend;
        if (!rst_n) begin
            m_ph = P_IDLE; m_pend = 0; m_txs = 0; m_evt = 0; m_evr = 0;
        end else begin
            m_evt  = !cmd_we && m_ph == P_TX && tx_done;
            m_evr  = !cmd_we && m_ph == P_RX && rx_frame;
            m_ph   = next_phase(m_ph, m_pend);
            m_pend = send_set ? 1'b1 : (fire ? 1'b0 : m_pend);
            m_txs  = fire;
        end
        @(posedge clk);
        #1;
        check({tag, " R2 phase"}, phase, m_ph);
        check({tag, " R2 rx_en"}, {1'b0, rx_en}, {1'b0, m_ph == P_RX});
        check({tag, " R4 pending"}, {1'b0, start_pending}, {1'b0, m_pend});
        check({tag, " R4 tx_start"}, {1'b0, tx_start}, {1'b0, m_txs});
        check({tag, " R5 ev_tx"}, {1'b0, ev_tx_done}, {1'b0, m_evt});
        check({tag, " R6 ev_rx"}, {1'b0, ev_rx_frame}, {1'b0, m_evr});
        check({tag, " R12 overlap"}, {1'b0, tx_start && rx_en}, 2'b00);
        @(negedge clk);
        cmd_we = 0; send_set = 0; tx_done = 0; rx_frame = 0;
    endtask

    task automatic write_cmd(logic [3:0] c, logic init);
        cmd_we = 1; cmd_code = c; initiator = init;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        m_ph = P_IDLE; m_pend = 0; m_txs = 0; m_evt = 0; m_evr = 0;
        @(negedge clk);
        rst_n = 0; send_set = 1; tx_done = 1; rx_frame = 1;
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;
        // R8: strobes in idle ignored; R9 idle not left by other codes.
        tx_done = 1; rx_frame = 1; step("R8 idle strobes");
        write_cmd(4'h0, 1); step("R9 idle write");
        // R3: initiator 1 starts in wait-send, send loop.
        write_cmd(XCV, 1); step("R3 start tx-first");
        rx_frame = 1; step("R8 rx in wait");
        send_set = 1; step("R4 arm");
        step("R4 launch");
        send_set = 1; step("R4 arm in tx");
        tx_done = 1; step("R5 tx done");
        tx_done = 1; step("R8 tx in rx");
        rx_frame = 1; step("R6 frame");
        step("R4 relaunch from armed");
        // R11: command write clashes with tx_done.
        tx_done = 1; write_cmd(XCV, 0); step("R11 clash R10 restart");
        // R7: receive-multiple lock.
        rx_multi = 1;
        for (int i = 0; i < 20; i++) begin rx_frame = 1; step("R7 lock"); end
        rx_multi = 0;
        rx_frame = 1; write_cmd(4'h3, 0); step("R11 R9 stop");
        // R10 restart from wait with armed start: no launch.
        write_cmd(XCV, 1); step("R10 start");
        send_set = 1; step("R4 arm");
        write_cmd(XCV, 1); step("R11 R10 restart while armed");
        step("R4 launch after restart");
        write_cmd(XCV, 0); step("R10 restart from tx");
        // Long random run.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) begin
                cmd_we = 1;
                cmd_code = $urandom_range(1) ? XCV : 4'($urandom_range(15));
            end
            if ($urandom_range(7) == 0) initiator = $urandom_range(1) == 1;
            if ($urandom_range(31) == 0) rx_multi = ~rx_multi;
            send_set = $urandom_range(3) == 0;
            tx_done  = $urandom_range(2) == 0;
            rx_frame = $urandom_range(2) == 0;
            rst_n    = $urandom_range(500) != 0;
            step(rst_n ? "R2 random" : "R1 random reset");
            rst_n = 1;
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule